// File: doc/BRIEF.md
# Masked Internal Processor Register File

This block holds the internal control registers of a processor core. Software running at the privileged level reaches them by a small index, one access per cycle, through a single request port that either reads or writes. Each index has its own rule. Some keep every bit of a write. Some keep only certain bit fields. Some clear themselves on any write. Some may only be read, others may only be written, and an index that names no register refuses both. A refused access finishes with a fault flag and leaves all state untouched.

Several indices are not storage at all. A write to them sends a one-cycle command to the two translation buffers, which sit outside this block: invalidate everything, invalidate the current process, invalidate one address, or insert an entry. An insert carries a page-table entry. That entry is assembled from fields staged earlier in a holding register, together with the address-space number currently held for that buffer. One register also returns the low half of a free-running cycle counter when read.

Each access answers on the next cycle with `rsp_valid`, `rsp_fault` and `rsp_rdata`. A command to the translation buffers appears in the same cycle as that answer.

Top module: `ipr_file`

## Requirements
- R1: After reset every readable index reads 0, except index 24 (privileged base), which reads the parameter `BASE_RST`. No response and no command is pending after reset. Every access, and only an access, produces `rsp_valid` high on the cycle after it is presented.
- R2: Indices 0 to 23 (scratch) and index 24 (privileged base) keep all 64 bits of a write and read them back unchanged. Index 54 (instruction tag) also keeps all 64 bits of a write.
- R3: These indices store only the bits of the write that fall inside their mask and read back that masked value:
  - 26 and 27: 0xf
  - 28: 0x1f
  - 29: 0x18
  - 31: 0x7fff0
  - 32: 0xffffff0300
  - 33 and 34: 0xffffffffc0000000
  - 35: 0x1ffb
  - 36 and 37: 0x3f
  - 38: 0x7f0
  - 39: 0xfe00000000000000
- R4: Any write to index 40 or index 41 sets that register to zero, whatever the write data.
- R5: A write to indices 42 to 46 sets `rsp_fault` and leaves the register unchanged. Reads of these indices succeed.
- R6: A read of index 30, of indices 47 to 50, or of indices 52 to 60 sets `rsp_fault` and returns 0 on `rsp_rdata`. Writes to these indices succeed without a fault.
- R7: Indices 61 to 63 fault on both read and write.
- R8: A read of index 25 returns bits 63:32 as stored by the last write, and bits 31:0 from a counter. The counter is cleared by reset and advances by one on every clock edge out of reset.
- R9: A read of index 51 returns a packed word built from the staged value S (last write to 51) and A = bits 63:57 of index 39. S[58:32] goes to bits 58:32, S[15:8] to bits 15:8, and S bits 4, 2 and 1 to the same positions. A is then OR-ed into bits 63:57. All other bits read 0.
- R10: A write of value V to index 52 emits a command with `tlb_instr`=0, `tlb_op`=3 (insert) and `tlb_addr`=V. `tlb_pte` is packed, most significant field first, as {asn[6:0], ppn[26:0], rd_en[3:0], wr_en[3:0], flt_rd, flt_wr, asm}. For this command it is taken from the staged S: ppn=S[58:32], rd_en=S[11:8], wr_en=S[15:12], flt_rd=S[1], flt_wr=S[2], asm=S[4], and asn=A.
- R11: A write of value V to index 53 emits `tlb_instr`=1 and `tlb_op`=3, with `tlb_addr` equal to index 54. The entry takes its fields from V at the same positions as in R10, with wr_en=0, and asn equal to bits 10:4 of index 38.
- R12: Writes to indices 55, 56 and 57 emit data-buffer commands, and writes to 58, 59 and 60 emit instruction-buffer commands. The operations are 0 (invalidate all), 1 (invalidate process) and 2 (invalidate one address), in that order. For operation 2, `tlb_addr` is the write data and only the asn field of `tlb_pte` is set, to that buffer's current asn. For operations 0 and 1, address and entry are 0.
- R13: `tlb_valid` stays high for exactly one cycle per command write. A faulted access, a read, or a write to a non-command index emits no command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_idx | input | IDX_W | Register index |
| acc_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response for the access of the previous cycle |
| rsp_fault | output | 1 | Access refused (unimplemented-operation fault) |
| rsp_rdata | output | 64 | Read data, 0 on writes and faults |
| tlb_valid | output | 1 | Translation-buffer command pulse |
| tlb_instr | output | 1 | 1 = instruction buffer, 0 = data buffer |
| tlb_op | output | 2 | 0 invalidate all, 1 invalidate process, 2 invalidate one, 3 insert |
| tlb_addr | output | 64 | Address or tag of the command |
| tlb_pte | output | 45 | Packed entry {asn, ppn, rd_en, wr_en, flt_rd, flt_wr, asm} |

## Verification
The properties assume that `acc_idx`, `acc_write` and `acc_wdata` are known whenever `acc_valid` is high, and that no access is presented while reset is held. The counter property assumes the counter may wrap freely. The bench changes inputs only on falling edges and leaves one idle cycle between accesses. It raises `acc_valid` only after reset is released, so every response and command pulse can be tied to a single access. A full index sweep runs with several data patterns, and each result is compared with a mask, fault and packing table that the bench computes on its own.

// File: rtl/ipr_pkg.sv
package ipr_pkg;

    // Offsets of the named registers above the scratch bank
    localparam int K_BASE   = 0;
    localparam int K_CYC    = 1;
    localparam int K_AST_RQ = 2;
    localparam int K_AST_EN = 3;
    localparam int K_IPL    = 4;
    localparam int K_MODE   = 5;
    localparam int K_ALT    = 6;
    localparam int K_SWRQ   = 7;
    localparam int K_CSR    = 8;
    localparam int K_IPTB   = 9;
    localparam int K_DPTB   = 10;
    localparam int K_CTEST  = 11;
    localparam int K_DCMODE = 12;
    localparam int K_MBMODE = 13;
    localparam int K_IASN   = 14;
    localparam int K_DASN   = 15;
    localparam int K_XSUM   = 16;
    localparam int K_XMASK  = 17;
    localparam int K_INTID  = 18;
    localparam int K_SRX    = 19;
    localparam int K_MMST   = 20;
    localparam int K_ITMP   = 21;
    localparam int K_DTMP   = 22;
    localparam int K_HWCLR  = 23;
    localparam int K_STX    = 24;
    localparam int K_DFL    = 25;
    localparam int K_IFL    = 26;
    localparam int K_DPTE   = 27;
    localparam int K_DTAG   = 28;
    localparam int K_IPTE   = 29;
    localparam int K_ITAG   = 30;
    localparam int K_DINVA  = 31;
    localparam int K_DINVP  = 32;
    localparam int K_DINVS  = 33;
    localparam int K_IINVA  = 34;
    localparam int K_IINVP  = 35;
    localparam int K_IINVS  = 36;
    localparam int K_COUNT  = 37;

    localparam logic [63:0] M_AST   = 64'h0000_0000_0000_000f;
    localparam logic [63:0] M_IPL   = 64'h0000_0000_0000_001f;
    localparam logic [63:0] M_MODE  = 64'h0000_0000_0000_0018;
    localparam logic [63:0] M_SWRQ  = 64'h0000_0000_0007_fff0;
    localparam logic [63:0] M_CSR   = 64'h0000_00ff_ffff_0300;
    localparam logic [63:0] M_PTB   = 64'hffff_ffff_c000_0000;
    localparam logic [63:0] M_CTEST = 64'h0000_0000_0000_1ffb;
    localparam logic [63:0] M_CMODE = 64'h0000_0000_0000_003f;
    localparam logic [63:0] M_IASN  = 64'h0000_0000_0000_07f0;
    localparam logic [63:0] M_DASN  = 64'hfe00_0000_0000_0000;

    typedef enum logic [1:0] {
        OP_INV_ALL  = 2'd0,
        OP_INV_PROC = 2'd1,
        OP_INV_ONE  = 2'd2,
        OP_INSERT   = 2'd3
    } tlb_op_e;

    typedef enum logic [1:0] {
        RD_PLAIN = 2'd0,
        RD_CYCLE = 2'd1,
        RD_DPTE  = 2'd2
    } rd_kind_e;

    typedef struct packed {
        logic [6:0]  asn;
        logic [26:0] ppn;
        logic [3:0]  rd_en;
        logic [3:0]  wr_en;
        logic        flt_rd;
        logic        flt_wr;
        logic        asm_m;
    } pte_t;

    typedef struct packed {
        logic [63:0] wmask;
        logic        rd_fault;
        logic        wr_fault;
        logic        wr_clear;
        logic        strobe;
        logic        str_instr;
        tlb_op_e     op;
        rd_kind_e    rdk;
    } attr_t;

endpackage

// File: rtl/ipr_decode.sv
module ipr_decode
    import ipr_pkg::*;
#(
    parameter int IDX_W     = 6,
    parameter int SCRATCH_N = 24
) (
    input  logic [IDX_W-1:0] idx,
    output attr_t            attr
);

    always_comb begin
        attr           = '0;
        attr.op        = OP_INV_ALL;
        attr.rdk       = RD_PLAIN;
        if (int'(idx) < SCRATCH_N) begin
            attr.wmask = '1;
        end else begin
            case (int'(idx) - SCRATCH_N)
                K_BASE:             attr.wmask = '1;
                K_CYC: begin
                    attr.wmask = '1;
                    attr.rdk   = RD_CYCLE;
                end
                K_AST_RQ, K_AST_EN: attr.wmask = M_AST;
                K_IPL:              attr.wmask = M_IPL;
                K_MODE:             attr.wmask = M_MODE;
                K_ALT: begin
                    attr.wmask    = M_MODE;
                    attr.rd_fault = 1'b1;
                end
                K_SWRQ:             attr.wmask = M_SWRQ;
                K_CSR:              attr.wmask = M_CSR;
                K_IPTB, K_DPTB:     attr.wmask = M_PTB;
                K_CTEST:            attr.wmask = M_CTEST;
                K_DCMODE, K_MBMODE: attr.wmask = M_CMODE;
                K_IASN:             attr.wmask = M_IASN;
                K_DASN:             attr.wmask = M_DASN;
                K_XSUM, K_XMASK:    attr.wr_clear = 1'b1;
                K_INTID, K_SRX, K_MMST, K_ITMP, K_DTMP:
                    attr.wr_fault = 1'b1;
                K_HWCLR, K_STX, K_DFL, K_IFL:
                    attr.rd_fault = 1'b1;
                K_DPTE: begin
                    attr.wmask = '1;
                    attr.rdk   = RD_DPTE;
                end
                K_DTAG: begin
                    attr.rd_fault = 1'b1;
                    attr.strobe   = 1'b1;
                    attr.op       = OP_INSERT;
                end
                K_IPTE: begin
                    attr.rd_fault  = 1'b1;
                    attr.strobe    = 1'b1;
                    attr.str_instr = 1'b1;
                    attr.op        = OP_INSERT;
                end
                K_ITAG: begin
                    attr.rd_fault = 1'b1;
                    attr.wmask    = '1;
                end
                K_DINVA, K_DINVP, K_DINVS: begin
                    attr.rd_fault = 1'b1;
                    attr.strobe   = 1'b1;
                    attr.op       = tlb_op_e'(2'(int'(idx) - SCRATCH_N - K_DINVA));
                end
                K_IINVA, K_IINVP, K_IINVS: begin
                    attr.rd_fault  = 1'b1;
                    attr.strobe    = 1'b1;
                    attr.str_instr = 1'b1;
                    attr.op        = tlb_op_e'(2'(int'(idx) - SCRATCH_N - K_IINVA));
                end
                default: begin
                    attr.rd_fault = 1'b1;
                    attr.wr_fault = 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/ipr_cycle_counter.sv
module ipr_cycle_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] count
);

    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= count + 1'b1;
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> count == $past(count) + 1'b1); // R8

endmodule

// File: rtl/ipr_pte_build.sv
module ipr_pte_build
    import ipr_pkg::*;
(
    input  logic [63:0] src,
    input  logic [6:0]  asn,
    output pte_t        pte
);

    logic unused_src_bits;
    assign unused_src_bits = ^{src[63:59], src[31:16], src[7:5], src[3], src[0]};

    always_comb begin
        pte.asn    = asn;
        pte.ppn    = src[58:32];
        pte.rd_en  = src[11:8];
        pte.wr_en  = src[15:12];
        pte.flt_rd = src[1];
        pte.flt_wr = src[2];
        pte.asm_m  = src[4];
    end

endmodule

// File: rtl/ipr_file.sv
module ipr_file
    import ipr_pkg::*;
#(
    parameter int          IDX_W     = 6,
    parameter int          SCRATCH_N = 24,
    parameter int          CNT_W     = 32,
    parameter logic [63:0] BASE_RST  = 64'h0000_0000_0001_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic             acc_write,
    input  logic [IDX_W-1:0] acc_idx,
    input  logic [63:0]      acc_wdata,
    output logic             rsp_valid,
    output logic             rsp_fault,
    output logic [63:0]      rsp_rdata,
    output logic             tlb_valid,
    output logic             tlb_instr,
    output logic [1:0]       tlb_op,
    output logic [63:0]      tlb_addr,
    output logic [44:0]      tlb_pte
);

    localparam int NREG      = 1 << IDX_W;
    localparam int IDX_BASE  = SCRATCH_N + K_BASE;
    localparam int IDX_CYC   = SCRATCH_N + K_CYC;
    localparam int IDX_IPL   = SCRATCH_N + K_IPL;
    localparam int IDX_IASN  = SCRATCH_N + K_IASN;
    localparam int IDX_DASN  = SCRATCH_N + K_DASN;
    localparam int IDX_XSUM  = SCRATCH_N + K_XSUM;
    localparam int IDX_INTID = SCRATCH_N + K_INTID;
    localparam int IDX_DPTE  = SCRATCH_N + K_DPTE;
    localparam int IDX_ITAG  = SCRATCH_N + K_ITAG;

    if (SCRATCH_N + K_COUNT > NREG) begin : g_bad_size
        $error("index space too small for the register map");
    end

    attr_t            attr;
    logic [63:0]      store [NREG];
    logic [CNT_W-1:0] cyc_cnt;
    pte_t             d_pte;
    pte_t             i_pte;
    logic [63:0]      rd_word;
    logic [63:0]      dpte_word;
    logic [63:0]      nx_addr;
    pte_t             nx_pte;
    logic             wr_go;
    logic             strobe_go;
    logic             acc_fault;

    ipr_decode #(.IDX_W(IDX_W), .SCRATCH_N(SCRATCH_N)) u_decode (
        .idx  (acc_idx),
        .attr (attr)
    );

    ipr_cycle_counter #(.CNT_W(CNT_W)) u_cycle (
        .clk   (clk),
        .rst_n (rst_n),
        .count (cyc_cnt)
    );

    ipr_pte_build u_dpte (
        .src (store[IDX_DPTE]),
        .asn (store[IDX_DASN][63:57]),
        .pte (d_pte)
    );

    ipr_pte_build u_ipte (
        .src (acc_wdata),
        .asn (store[IDX_IASN][10:4]),
        .pte (i_pte)
    );

    assign acc_fault = acc_valid & (acc_write ? attr.wr_fault : attr.rd_fault);
    assign wr_go     = acc_valid & acc_write & ~attr.wr_fault;
    assign strobe_go = wr_go & attr.strobe;

    // Register storage: masked, clear-on-write or full writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) store[i] <= '0;
            store[IDX_BASE] <= BASE_RST;
        end else if (wr_go) begin
            store[acc_idx] <= attr.wr_clear ? '0 : (acc_wdata & attr.wmask);
        end
    end

    // Read path with the two special read formats
    always_comb begin
        dpte_word         = '0;
        dpte_word[58:32]  = d_pte.ppn;
        dpte_word[15:12]  = d_pte.wr_en;
        dpte_word[11:8]   = d_pte.rd_en;
        dpte_word[4]      = d_pte.asm_m;
        dpte_word[2]      = d_pte.flt_wr;
        dpte_word[1]      = d_pte.flt_rd;
        dpte_word[63:57]  = dpte_word[63:57] | d_pte.asn;
    end

    always_comb begin
        case (attr.rdk)
            RD_CYCLE: rd_word = {store[IDX_CYC][63:CNT_W], cyc_cnt};
            RD_DPTE:  rd_word = dpte_word;
            default:  rd_word = store[acc_idx];
        endcase
    end

    // Command address and entry for the translation buffers
    always_comb begin
        nx_addr = '0;
        nx_pte  = '0;
        case (attr.op)
            OP_INSERT: begin
                if (attr.str_instr) begin
                    nx_addr      = store[IDX_ITAG];
                    nx_pte       = i_pte;
                    nx_pte.wr_en = '0;
                end else begin
                    nx_addr = acc_wdata;
                    nx_pte  = d_pte;
                end
            end
            OP_INV_ONE: begin
                nx_addr    = acc_wdata;
                nx_pte.asn = attr.str_instr ? store[IDX_IASN][10:4]
                                            : store[IDX_DASN][63:57];
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_fault <= 1'b0;
            rsp_rdata <= '0;
            tlb_valid <= 1'b0;
            tlb_instr <= 1'b0;
            tlb_op    <= '0;
            tlb_addr  <= '0;
            tlb_pte   <= '0;
        end else begin
            rsp_valid <= acc_valid;
            rsp_fault <= acc_fault;
            rsp_rdata <= (acc_valid & ~acc_write & ~attr.rd_fault) ? rd_word : '0;
            tlb_valid <= strobe_go;
            tlb_instr <= strobe_go & attr.str_instr;
            tlb_op    <= strobe_go ? attr.op : 2'b00;
            tlb_addr  <= strobe_go ? nx_addr : '0;
            tlb_pte   <= strobe_go ? nx_pte : '0;
        end
    end

    AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> rsp_valid); // R1
    AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !rsp_valid); // R1
    AST_IPL_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && int'(acc_idx) == IDX_IPL)
        |=> store[IDX_IPL][63:5] == '0); // R3
    AST_CLEAR_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && int'(acc_idx) == IDX_XSUM)
        |=> store[IDX_XSUM] == '0); // R4
    AST_RO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && int'(acc_idx) == IDX_INTID)
        |=> $stable(store[IDX_INTID])); // R5
    AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> !tlb_valid); // R13
    AST_CMD_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_valid |-> rsp_valid); // R13

endmodule

// File: tb/ipr_file_bench.sv
`timescale 1ns/1ps
module ipr_file_bench;

    localparam logic [63:0] BASE_RST = 64'h0000_0000_0001_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [5:0]  acc_idx = '0;
    logic [63:0] acc_wdata = '0;
    logic        rsp_valid, rsp_fault, tlb_valid, tlb_instr;
    logic [63:0] rsp_rdata, tlb_addr;
    logic [1:0]  tlb_op;
    logic [44:0] tlb_pte;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [63:0] mdl [64];
    logic [63:0] cyc_m;
    logic [63:0] snap;

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) cyc_m <= '0;
        else        cyc_m <= cyc_m + 1;
    end

    ipr_file #(.IDX_W(6), .SCRATCH_N(24), .CNT_W(32), .BASE_RST(BASE_RST)) u_ipr_file (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_idx(acc_idx), .acc_wdata(acc_wdata), .rsp_valid(rsp_valid),
        .rsp_fault(rsp_fault), .rsp_rdata(rsp_rdata), .tlb_valid(tlb_valid),
        .tlb_instr(tlb_instr), .tlb_op(tlb_op), .tlb_addr(tlb_addr), .tlb_pte(tlb_pte)
    );

    task automatic chk(input string req, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input int i);
        if (i < 25) return "R2";
        if (i == 25) return "R8";
        if (i == 30) return "R6";
        if (i < 40) return "R3";
        if (i < 42) return "R4";
        if (i < 47) return "R5";
        if (i < 51) return "R6";
        if (i == 51) return "R9";
        if (i == 52) return "R10";
        if (i == 53) return "R11";
        if (i == 54) return "R6";
        if (i < 61) return "R12";
        return "R7";
    endfunction

    function automatic logic [63:0] f_mask(input int i);
        if (i < 26) return '1;
        case (i)
            26, 27: return 64'hf;
            28:     return 64'h1f;
            29, 30: return 64'h18;
            31:     return 64'h7fff0;
            32:     return 64'hff_ffff_0300;
            33, 34: return 64'hffff_ffff_c000_0000;
            35:     return 64'h1ffb;
            36, 37: return 64'h3f;
            38:     return 64'h7f0;
            39:     return 64'hfe00_0000_0000_0000;
            51, 54: return '1;
            default: return '0;
        endcase
    endfunction

    function automatic bit f_wrf(input int i);
        return (i >= 42 && i <= 46) || i >= 61;
    endfunction

    function automatic bit f_rdf(input int i);
        return i == 30 || (i >= 47 && i <= 50) || (i >= 52 && i <= 60) || i >= 61;
    endfunction

    function automatic logic [44:0] f_pte(input logic [63:0] s, input logic [6:0] a,
                                          input bit keep_wr);
        return {a, s[58:32], s[11:8], keep_wr ? s[15:12] : 4'h0, s[1], s[2], s[4]};
    endfunction

    function automatic logic [63:0] f_rd(input int i, input logic [63:0] cyc);
        logic [63:0] s;
        logic [63:0] a;
        if (f_rdf(i)) return '0;
        if (i == 25) return {mdl[25][63:32], cyc[31:0]};
        if (i == 51) begin
            s = mdl[51];
            a = {57'b0, mdl[39][63:57]};
            return (((s >> 32) & 64'h7ff_ffff) << 32) | (((s >> 8) & 64'hff) << 8)
                   | (s & 64'h16) | (a << 57);
        end
        return mdl[i];
    endfunction

    task automatic do_acc(input bit w, input int i, input logic [63:0] d);
        @(negedge clk);
        acc_valid = 1'b1;
        acc_write = w;
        acc_idx   = i[5:0];
        acc_wdata = d;
        snap      = cyc_m;
        @(negedge clk);
        acc_valid = 1'b0;
        acc_write = 1'b0;
        chk("R1", "rsp_valid", {63'b0, rsp_valid}, 64'd1);
    endtask

    task automatic write_and_check(input int i, input logic [63:0] d);
        bit          ev;
        bit          ei;
        logic [1:0]  eo;
        logic [63:0] ea;
        logic [44:0] ep;
        string       r;
        ev = 1'b0; ei = 1'b0; eo = 2'd0; ea = '0; ep = '0;
        r = req_of(i);
        case (i)
            52: begin ev = 1; eo = 3; ea = d; ep = f_pte(mdl[51], mdl[39][63:57], 1'b1); end
            53: begin ev = 1; ei = 1; eo = 3; ea = mdl[54]; ep = f_pte(d, mdl[38][10:4], 1'b0); end
            55: begin ev = 1; eo = 0; end
            56: begin ev = 1; eo = 1; end
            57: begin ev = 1; eo = 2; ea = d; ep = {mdl[39][63:57], 38'b0}; end
            58: begin ev = 1; ei = 1; eo = 0; end
            59: begin ev = 1; ei = 1; eo = 1; end
            60: begin ev = 1; ei = 1; eo = 2; ea = d; ep = {mdl[38][10:4], 38'b0}; end
            default: ;
        endcase
        do_acc(1'b1, i, d);
        chk(r, $sformatf("write fault idx %0d", i), {63'b0, rsp_fault}, {63'b0, f_wrf(i)});
        chk(ev ? r : "R13", $sformatf("tlb_valid idx %0d", i), {63'b0, tlb_valid}, {63'b0, ev});
        if (ev) begin
            chk(r, "tlb_instr", {63'b0, tlb_instr}, {63'b0, ei});
            chk(r, "tlb_op", {62'b0, tlb_op}, {62'b0, eo});
            chk(r, "tlb_addr", tlb_addr, ea);
            chk(r, "tlb_pte", {19'b0, tlb_pte}, {19'b0, ep});
        end
        if (!f_wrf(i)) begin
            if (i == 40 || i == 41) mdl[i] = '0;
            else mdl[i] = d & f_mask(i);
        end
    endtask

    task automatic read_and_check(input int i, input string r);
        do_acc(1'b0, i, 64'hdead_beef_dead_beef);
        chk(r, $sformatf("read fault idx %0d", i), {63'b0, rsp_fault}, {63'b0, f_rdf(i)});
        chk(r, $sformatf("read data idx %0d", i), rsp_rdata, f_rd(i, snap));
        chk("R13", "no command on read", {63'b0, tlb_valid}, 64'd0);
    endtask

    initial begin
        logic [63:0] pats [3];
        pats[0] = '1;
        pats[1] = 64'h5a3c_96e1_0f87_d2b4;
        pats[2] = 64'h0123_4567_89ab_cdef;
        for (int i = 0; i < 64; i++) mdl[i] = '0;
        mdl[24] = BASE_RST;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "rsp_valid after reset", {63'b0, rsp_valid}, 64'd0);
        chk("R1", "tlb_valid after reset", {63'b0, tlb_valid}, 64'd0);
        for (int i = 0; i < 64; i++) read_and_check(i, "R1");
        for (int p = 0; p < 3; p++) begin
            for (int i = 0; i < 64; i++) begin
                write_and_check(i, pats[p]);
                read_and_check(i, req_of(i));
            end
        end
        // Clear-on-write after a nonzero value cannot arise; confirm zero read R4
        write_and_check(40, 64'hffff_0000_ffff_0000);
        read_and_check(40, "R4");
        // Counter moves between two reads of the merged register R8
        read_and_check(25, "R8");
        repeat (7) @(negedge clk);
        read_and_check(25, "R8");
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule